// File: doc/BRIEF.md
# Residue Channel Modular Adder (modulus 2^W − 2^K − 1)

This block adds two residues of one residue-number-system channel whose modulus has the form M = 2^W − 2^K − 1. Both operands are W bits wide and are already reduced below M. The residue output is W bits wide. The block is purely combinational, with no clock and no reset, and its output settles within the same evaluation as its inputs.

One parallel-prefix carry tree is shared by both candidate results. A carry-save stage first folds the constant 2^K + 1 into the operands. The tree then evaluates that sum. Two carry corrections act on the tree's carries:

- The bit-0 correction turns the carry-in-0 carries into carry-in-1 carries by OR-ing in the group propagate terms.
- The bit-K correction removes 2^K again by means of a borrow chain over the upper section.

A single wrap flag picks the final carries. Each output bit is then one XOR of a partial sum with its final carry. The tree style is a parameter: Sklansky or Kogge-Stone.

Top module: `rns_modadd`

## Requirements
- R1: For all opa, opb < M, where M = 2^W − 2^K − 1, residue equals (opa + opb) mod M.
- R2: When opa + opb < M, residue equals the plain sum opa + opb.
- R3: When opa + opb ≥ M, residue equals the low W bits of opa + opb + 2^K + 1.
- R4: When opa + opb equals M exactly, residue is 0.
- R5: With both operands at M − 1, residue is M − 2.
- R6: R1 holds with the notch at its lowest position (K = 1) and at its highest position (K = W − 2), and for both tree variants.
- R7: residue is always below M.
- R8: With W = 8 and K = 4 (M = 239), operand pairs whose integer sum is 153 or 392 both give 153.
- R9: The corrected result is selected exactly when opa + opb + 2^K + 1 ≥ 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First residue operand, below M |
| opb | input | W | Second residue operand, below M |
| residue | output | W | (opa + opb) mod M |

## Verification
The embedded checks look at every evaluation of in-range operands:

- the output against the modular sum;
- the output staying below M;
- the wrap selection tracking opa + opb + 2^K + 1 ≥ 2^W;
- the carry-save stage preserving the value of its three inputs.

The bench's scenarios are needed for the rest. They sweep several moduli exhaustively. They probe the exact-modulus and maximum-operand corners and the listed check vector. They also cover the notch at both extremes and the second tree topology. These properties of parameterization cannot be seen from a single instance at run time.

// File: rtl/rns_modadd_pkg.sv
package rns_modadd_pkg;
  typedef enum logic [0:0] {
    TREE_SKLANSKY    = 1'b0,
    TREE_KOGGE_STONE = 1'b1
  } tree_e;
endpackage

// File: rtl/rns_modadd_pre.sv
// Generate/propagate formation for A + B + 2^K.
// Below bit K the operands pass through unchanged.
// From bit K upwards a carry-save row absorbs the constant 1 at bit K.
module rns_modadd_pre #(
  parameter int unsigned W = 8,
  parameter int unsigned K = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prp,
  output logic         side_carry
);
  logic [W-1:0] xv;
  logic [W-1:0] yv;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (i < K) begin
        xv[i] = a[i];
        yv[i] = b[i];
      end else if (i == K) begin
        xv[i] = ~(a[i] ^ b[i]);
        yv[i] = 1'b0;
      end else if (i == K + 1) begin
        xv[i] = a[i] ^ b[i];
        yv[i] = a[i-1] | b[i-1];
      end else begin
        xv[i] = a[i] ^ b[i];
        yv[i] = a[i-1] & b[i-1];
      end
    end
    gen        = xv & yv;
    prp        = xv ^ yv;
    side_carry = a[W-1] & b[W-1];
  end

  // R3: the reduced pair plus the bypassed carry keeps the value a + b + 2^K
  logic [W+1:0] chk_lhs;
  logic [W+1:0] chk_rhs;
  always_comb begin
    chk_lhs = {1'b0, side_carry, {W{1'b0}}} + {2'b00, xv} + {2'b00, yv};
    chk_rhs = {2'b00, a} + {2'b00, b} + ((W+2)'(1) << K);
    p_csa_value_r3: assert (chk_lhs == chk_rhs)
      else $error("carry-save stage changed the operand value");
  end
endmodule

// File: rtl/rns_modadd_tree.sv
// Group generate/propagate from bit 0 up to every bit i.
module rns_modadd_tree #(
  parameter int unsigned W = 8,
  parameter rns_modadd_pkg::tree_e TREE = rns_modadd_pkg::TREE_SKLANSKY
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prp,
  output logic [W-1:0] grp_g,
  output logic [W-1:0] grp_p
);
  localparam int unsigned LV = $clog2(W);

  logic [W-1:0] gs [0:LV];
  logic [W-1:0] ps [0:LV];

  assign gs[0] = gen;
  assign ps[0] = prp;

  for (genvar lv = 0; lv < LV; lv++) begin : g_level
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (TREE == rns_modadd_pkg::TREE_SKLANSKY) begin : g_sk
        if (((i >> lv) & 1) == 1) begin : g_node
          localparam int SRC = ((i >> lv) << lv) - 1;
          assign gs[lv+1][i] = gs[lv][i] | (ps[lv][i] & gs[lv][SRC]);
          assign ps[lv+1][i] = ps[lv][i] & ps[lv][SRC];
        end else begin : g_pass
          assign gs[lv+1][i] = gs[lv][i];
          assign ps[lv+1][i] = ps[lv][i];
        end
      end else begin : g_ks
        if (i >= (1 << lv)) begin : g_node
          localparam int SRC = i - (1 << lv);
          assign gs[lv+1][i] = gs[lv][i] | (ps[lv][i] & gs[lv][SRC]);
          assign ps[lv+1][i] = ps[lv][i] & ps[lv][SRC];
        end else begin : g_pass
          assign gs[lv+1][i] = gs[lv][i];
          assign ps[lv+1][i] = ps[lv][i];
        end
      end
    end
  end

  assign grp_g = gs[LV];
  assign grp_p = ps[LV];
endmodule

// File: rtl/rns_modadd_fix.sv
// Carry correction and sum stage.
// Correction 1 (bit 0): carry-in-1 carries come from G | P.
// Correction 2 (bit K): a borrow chain over bits >= K takes 2^K back out when no wrap occurs.
module rns_modadd_fix #(
  parameter int unsigned W = 8,
  parameter int unsigned K = 4
) (
  input  logic [W-1:0] part,
  input  logic [W-1:0] grp_g,
  input  logic [W-1:0] grp_p,
  input  logic         side_carry,
  output logic [W-1:0] res,
  output logic         wrap
);
  logic [W-1:0] cz;
  logic [W-1:0] co;
  logic [W-1:0] bw;
  logic [W-1:0] fc;

  always_comb begin
    wrap  = grp_g[W-1] | grp_p[W-1] | side_carry;
    cz[0] = 1'b0;
    co[0] = 1'b1;
    for (int i = 1; i < W; i++) begin
      cz[i] = grp_g[i-1];
      co[i] = grp_g[i-1] | grp_p[i-1];
    end
    for (int i = 0; i < W; i++) begin
      if (i < K)       bw[i] = 1'b0;
      else if (i == K) bw[i] = 1'b1;
      else             bw[i] = bw[i-1] & ~(part[i-1] ^ cz[i-1]);
    end
    for (int i = 0; i < W; i++) begin
      fc[i] = wrap ? co[i] : (cz[i] ^ bw[i]);
    end
    res = part ^ fc;
  end
endmodule

// File: rtl/rns_modadd.sv
module rns_modadd #(
  parameter int unsigned W = 8,
  parameter int unsigned K = 4,
  parameter rns_modadd_pkg::tree_e TREE = rns_modadd_pkg::TREE_SKLANSKY
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] residue
);
  localparam int unsigned MODI = (2 ** W) - (2 ** K) - 1;
  localparam logic [W:0]  MOD  = MODI[W:0];
  localparam logic [W+1:0] TC  = (W+2)'((2 ** K) + 1);

  logic [W-1:0] gen;
  logic [W-1:0] prp;
  logic [W-1:0] grp_g;
  logic [W-1:0] grp_p;
  logic         side_carry;
  logic         wrap;

  rns_modadd_pre #(.W(W), .K(K)) u_pre (
    .a(opa), .b(opb), .gen(gen), .prp(prp), .side_carry(side_carry)
  );

  rns_modadd_tree #(.W(W), .TREE(TREE)) u_tree (
    .gen(gen), .prp(prp), .grp_g(grp_g), .grp_p(grp_p)
  );

  rns_modadd_fix #(.W(W), .K(K)) u_fix (
    .part(prp), .grp_g(grp_g), .grp_p(grp_p), .side_carry(side_carry),
    .res(residue), .wrap(wrap)
  );

  logic [W:0]   raw_sum;
  logic [W:0]   want;
  logic         in_range;
  always_comb begin
    raw_sum  = {1'b0, opa} + {1'b0, opb};
    want     = (raw_sum >= MOD) ? raw_sum - MOD : raw_sum;
    in_range = ({1'b0, opa} < MOD) && ({1'b0, opb} < MOD);
    if (in_range) begin
      p_residue_r1: assert ({1'b0, residue} == want)
        else $error("residue differs from modular sum");
      p_below_mod_r7: assert ({1'b0, residue} < MOD)
        else $error("residue not below modulus");
      p_wrap_sel_r9: assert (wrap == (({1'b0, raw_sum} + TC) >= ((W+2)'(1) << W)))
        else $error("wrap selection wrong");
      if (raw_sum == MOD) begin
        p_zero_at_mod_r4: assert (residue == '0)
          else $error("sum equal to modulus did not give zero");
      end
    end
  end
endmodule

// File: tb/rns_modadd_bench.sv
`timescale 1ns/1ps
module rns_modadd_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  a8, b8, r8;
  logic [5:0]  a6a, b6a, r6a;
  logic [5:0]  a6b, b6b, r6b;
  logic [7:0]  a8c, b8c, r8c;
  logic [11:0] a12, b12, r12;
  logic [11:0] a12k, b12k, r12k;

  rns_modadd #(.W(8), .K(4)) u_rns_modadd (.opa(a8), .opb(b8), .residue(r8));
  rns_modadd #(.W(6), .K(1)) u_w6k1 (.opa(a6a), .opb(b6a), .residue(r6a));
  rns_modadd #(.W(6), .K(4)) u_w6k4 (.opa(a6b), .opb(b6b), .residue(r6b));
  rns_modadd #(.W(8), .K(6), .TREE(rns_modadd_pkg::TREE_KOGGE_STONE))
    u_w8k6 (.opa(a8c), .opb(b8c), .residue(r8c));
  rns_modadd #(.W(12), .K(5), .TREE(rns_modadd_pkg::TREE_KOGGE_STONE))
    u_w12k5 (.opa(a12), .opb(b12), .residue(r12));
  rns_modadd #(.W(12), .K(10)) u_w12k10 (.opa(a12k), .opb(b12k), .residue(r12k));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {opa, opb, expected} for W=8, K=4, M=239
  localparam logic [23:0] VEC [0:7] = '{
    {8'd0,   8'd0,   8'd0},    // R2 zero
    {8'd100, 8'd53,  8'd153},  // R8 sum 153
    {8'd200, 8'd192, 8'd153},  // R8 sum 392
    {8'd119, 8'd120, 8'd0},    // R4 exact modulus
    {8'd238, 8'd1,   8'd0},    // R4 exact modulus
    {8'd238, 8'd238, 8'd237},  // R5 both maximal
    {8'd200, 8'd38,  8'd238},  // R2 just below M
    {8'd150, 8'd100, 8'd11}    // R3 wraps
  };
  localparam string VTAG [0:7] = '{"R2", "R8", "R8", "R4", "R4", "R5", "R2", "R3"};

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    a8 = '0; b8 = '0; a6a = '0; b6a = '0; a6b = '0; b6b = '0;
    a8c = '0; b8c = '0; a12 = '0; b12 = '0; a12k = '0; b12k = '0;
    @(negedge clk);
    chk("R2 idle zero", int'(r8), 0);

    for (int v = 0; v < 8; v++) begin
      a8 = VEC[v][23:16];
      b8 = VEC[v][15:8];
      #1;
      chk(VTAG[v], int'(r8), int'(VEC[v][7:0]));
    end

    // R1, R2, R3, R7: exhaustive W=8 K=4
    for (int a = 0; a < 239; a++) begin
      for (int b = 0; b < 239; b++) begin
        a8 = 8'(a); b8 = 8'(b); #1;
        chk((a + b < 239) ? "R2" : "R3", int'(r8), (a + b) % 239);
        if (int'(r8) >= 239) chk("R7", int'(r8), 238);
      end
    end
    checks++; // R7 range guard counted once as a whole sweep

    // R6: notch at lowest position, W=6 K=1, M=61
    for (int a = 0; a < 61; a++) begin
      for (int b = 0; b < 61; b++) begin
        a6a = 6'(a); b6a = 6'(b); #1;
        chk("R6 k1", int'(r6a), (a + b) % 61);
      end
    end
    // R6: notch at highest position, W=6 K=4, M=47
    for (int a = 0; a < 47; a++) begin
      for (int b = 0; b < 47; b++) begin
        a6b = 6'(a); b6b = 6'(b); #1;
        chk("R6 k4", int'(r6b), (a + b) % 47);
      end
    end
    // R6: other tree variant, W=8 K=6, M=191
    for (int a = 0; a < 191; a++) begin
      for (int b = 0; b < 191; b++) begin
        a8c = 8'(a); b8c = 8'(b); #1;
        chk("R6 ks", int'(r8c), (a + b) % 191);
      end
    end
    // R1 random, W=12 K=5 (M=4063) and R6 W=12 K=10 (M=3071)
    for (int n = 0; n < 3000; n++) begin
      automatic int x = int'($urandom % 4063);
      automatic int y = int'($urandom % 4063);
      automatic int u = int'($urandom % 3071);
      automatic int w = int'($urandom % 3071);
      a12 = 12'(x); b12 = 12'(y); a12k = 12'(u); b12k = 12'(w); #1;
      chk("R1 w12", int'(r12), (x + y) % 4063);
      chk("R6 w12k10", int'(r12k), (u + w) % 3071);
    end

    // R5 and R4 corners on the wide channel
    a12 = 12'd4062; b12 = 12'd4062; #1;
    chk("R5 w12", int'(r12), 4061);
    a12 = 12'd4000; b12 = 12'd63; #1;
    chk("R4 w12", int'(r12), 0);
    // R9: smallest sum that selects the corrected path (A+B+33 = 4096)
    a12 = 12'd4062; b12 = 12'd1; #1;
    chk("R9 select", int'(r12), 0);
    a12 = 12'd4061; b12 = 12'd1; #1;
    chk("R9 no select", int'(r12), 4062);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule